// File: doc/BRIEF.md
# Masked Aligned Vector Move Unit

This block performs one packed single-precision move per request. It can load a vector register from memory, store a vector register to memory, or copy one vector register to another. The operand is 128, 256 or 512 bits wide, which is 4, 8 or 16 lanes of 32 bits. A memory operand has to sit on a boundary equal to its own size. If it does not, the block raises a general-protection fault and writes nothing. Per-lane masking can be enabled. Lanes that are not selected either keep their old contents (merge) or are cleared (zero).

A request is taken from a decoded-operation interface while the sequencer is idle. The sequencer then steps through named states. ST_IDLE moves to ST_CHECK when it accepts a request. ST_CHECK goes to ST_FAULT when the memory operand is misaligned. It goes to ST_MEMRD for an aligned memory load, and to ST_RDREG in every other case. ST_MEMRD moves to ST_MEMWAIT. ST_MEMWAIT moves to ST_RFWR. ST_RDREG goes to ST_MEMWR for a memory store and to ST_RFWR for any register destination. ST_RFWR and ST_MEMWR both move to ST_FINISH. ST_FINISH and ST_FAULT both return to ST_IDLE. Register writes carry a per-lane enable, and memory writes carry a per-byte enable. Because of this, merging never needs a read-modify-write.

Top module: `vmov_unit`

## Requirements
- R1: Width code 0/1/2 on `req_width` selects 4/8/16 lanes (code 3 acts as 2). Lane i is bits [32*i+31:32*i]. Memory byte b of the operand at address A is data bits [8*b+7:8*b] (little-endian). A load from memory copies every lane into the destination register. `mem_rdata` is valid in the cycle after `mem_rd_en`.
- R2: When the operand is in memory (`req_rm_mem`=1), the address must be a multiple of 16, 32 or 64 bytes for width code 0, 1 or 2. Otherwise `fault` pulses once, `done` does not pulse, and no register or memory byte changes.
- R3: A register-to-register move (`req_rm_mem`=0) never faults, whatever `req_addr` holds.
- R4: With `req_store`=0, the source is the r/m operand and the destination is register `req_reg_idx`. With `req_store`=1, the source is register `req_reg_idx` and the destination is the r/m operand: memory at `req_addr`, or register `req_rm_idx`.
- R5: With `req_mask_en`=0, every lane within the width is written and `req_mask` has no effect.
- R6: With masking on and `req_zero`=0, a destination register lane whose `req_mask` bit is 0 keeps its previous value.
- R7: With masking on and `req_zero`=1, a destination register lane whose `req_mask` bit is 0 is written as 0.
- R8: On a masked store to memory, the bytes of unselected lanes are not changed, and `req_zero` has no effect.
- R9: Lanes at or above the lane count of the width are left untouched, both in the destination register and in memory.
- R10: Each accepted request produces exactly one single-cycle pulse, either `done` or `fault`, never both together. A `req_valid` that arrives while a request is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_store | input | 1 | 0: r/m to register, 1: register to r/m |
| req_rm_mem | input | 1 | r/m operand is memory (1) or a register (0) |
| req_width | input | 2 | Width code 0=128, 1=256, 2=512 bits |
| req_mask_en | input | 1 | Enable per-lane masking |
| req_zero | input | 1 | Zero unselected register lanes instead of merging |
| req_mask | input | LANES | Lane select bits |
| req_reg_idx | input | RIDX_W | Register operand index |
| req_rm_idx | input | RIDX_W | r/m register index |
| req_addr | input | ADDR_W | r/m memory byte address |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_be | output | 4*LANES | Per-byte write enables |
| mem_wdata | output | 32*LANES | Memory write data |
| mem_rdata | input | 32*LANES | Memory read data, one cycle after the read strobe |
| rf_rd_idx | output | RIDX_W | Register read index (combinational read) |
| rf_rdata | input | 32*LANES | Register read data |
| rf_wr_en | output | 1 | Register write strobe |
| rf_wr_idx | output | RIDX_W | Register write index |
| rf_wr_lane_en | output | LANES | Per-lane register write enables |
| rf_wdata | output | 32*LANES | Register write data |
| done | output | 1 | Request completed |
| fault | output | 1 | General-protection fault on misalignment |

## Verification
The hardest situations to reach are a misaligned operand that is still aligned to a smaller width, and a request that arrives while another is in flight. The bench sweeps every byte offset from 1 to 63 for every width in both directions. It then compares the entire register file and the entire memory image against a shadow model, so a single stray byte is caught. For the in-flight case, it pulses a second request two cycles after the first, while the sequencer is mid-operation. It then checks that the second request's destination register stays unchanged and that only one completion pulse appears.

// File: rtl/vmov_pkg.sv
package vmov_pkg;

    localparam int LANE_W = 32;

    typedef enum logic [1:0] {
        VW_128 = 2'd0,
        VW_256 = 2'd1,
        VW_512 = 2'd2,
        VW_RSV = 2'd3
    } vwidth_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_RDREG,
        ST_MEMRD,
        ST_MEMWAIT,
        ST_RFWR,
        ST_MEMWR,
        ST_FINISH,
        ST_FAULT
    } vstate_e;

    typedef struct packed {
        logic    store;
        logic    rm_mem;
        vwidth_e width;
        logic    mask_en;
        logic    zero;
    } vreq_ctl_t;

    function automatic int lanes_of(vwidth_e w);
        case (w)
            VW_128:  return 4;
            VW_256:  return 8;
            default: return 16;
        endcase
    endfunction

endpackage

// File: rtl/vmov_align_chk.sv
module vmov_align_chk
    import vmov_pkg::*;
(
    input  logic [5:0] addr_lo,
    input  vwidth_e    width,
    output logic       misaligned
);

    always_comb begin
        unique case (width)
            VW_128:  misaligned = |addr_lo[3:0];
            VW_256:  misaligned = |addr_lo[4:0];
            default: misaligned = |addr_lo[5:0];
        endcase
    end

endmodule

// File: rtl/vmov_lane_ctl.sv
module vmov_lane_ctl
    import vmov_pkg::*;
#(
    parameter int LANES = 16
) (
    input  vwidth_e                   width,
    input  logic                      mask_en,
    input  logic                      zero,
    input  logic                      to_mem,
    input  logic [LANES-1:0]          mask,
    input  logic [LANES*LANE_W-1:0]   src,
    output logic [LANES-1:0]          lane_wr,
    output logic [LANES*4-1:0]        byte_en,
    output logic [LANES*LANE_W-1:0]   wdata
);

    int n_lanes;
    assign n_lanes = lanes_of(width);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic in_w;
        logic sel;
        assign in_w = (i < n_lanes);
        assign sel  = in_w & (~mask_en | mask[i]);
        // register destinations may also clear unselected lanes
        assign lane_wr[i] = sel | (in_w & mask_en & zero & ~to_mem);
        assign byte_en[4*i +: 4] = {4{sel}};
        assign wdata[LANE_W*i +: LANE_W] = sel ? src[LANE_W*i +: LANE_W] : '0;
    end

endmodule

// File: rtl/vmov_ctrl.sv
module vmov_ctrl
    import vmov_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic store,
    input  logic rm_mem,
    input  logic misaligned,
    output logic latch_req,
    output logic cap_rf,
    output logic cap_mem,
    output logic mem_rd_en,
    output logic mem_wr_en,
    output logic rf_wr_en,
    output logic done,
    output logic fault
);

    vstate_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_CHECK;
            ST_CHECK: begin
                if (rm_mem && misaligned)  state_d = ST_FAULT;
                else if (rm_mem && !store) state_d = ST_MEMRD;
                else                       state_d = ST_RDREG;
            end
            ST_RDREG:   state_d = (store && rm_mem) ? ST_MEMWR : ST_RFWR;
            ST_MEMRD:   state_d = ST_MEMWAIT;
            ST_MEMWAIT: state_d = ST_RFWR;
            ST_RFWR:    state_d = ST_FINISH;
            ST_MEMWR:   state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_IDLE;
            ST_FAULT:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        latch_req = 1'b0;
        cap_rf    = 1'b0;
        cap_mem   = 1'b0;
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        rf_wr_en  = 1'b0;
        done      = 1'b0;
        fault     = 1'b0;
        unique case (state_q)
            ST_IDLE:    latch_req = req_valid;
            ST_RDREG:   cap_rf    = 1'b1;
            ST_MEMRD:   mem_rd_en = 1'b1;
            ST_MEMWAIT: cap_mem   = 1'b1;
            ST_RFWR:    rf_wr_en  = 1'b1;
            ST_MEMWR:   mem_wr_en = 1'b1;
            ST_FINISH:  done      = 1'b1;
            ST_FAULT:   fault     = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/vmov_unit.sv
module vmov_unit
    import vmov_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int ADDR_W = 32,
    parameter int RIDX_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_store,
    input  logic                    req_rm_mem,
    input  logic [1:0]              req_width,
    input  logic                    req_mask_en,
    input  logic                    req_zero,
    input  logic [LANES-1:0]        req_mask,
    input  logic [RIDX_W-1:0]       req_reg_idx,
    input  logic [RIDX_W-1:0]       req_rm_idx,
    input  logic [ADDR_W-1:0]       req_addr,
    output logic                    mem_rd_en,
    output logic                    mem_wr_en,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [LANES*4-1:0]      mem_be,
    output logic [LANES*32-1:0]     mem_wdata,
    input  logic [LANES*32-1:0]     mem_rdata,
    output logic [RIDX_W-1:0]       rf_rd_idx,
    input  logic [LANES*32-1:0]     rf_rdata,
    output logic                    rf_wr_en,
    output logic [RIDX_W-1:0]       rf_wr_idx,
    output logic [LANES-1:0]        rf_wr_lane_en,
    output logic [LANES*32-1:0]     rf_wdata,
    output logic                    done,
    output logic                    fault
);

    localparam int DATA_W = LANES * LANE_W;

    vreq_ctl_t           ctl_q;
    logic [LANES-1:0]    mask_q;
    logic [RIDX_W-1:0]   reg_q, rm_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   data_q;

    logic latch_req, cap_rf, cap_mem, misaligned;
    logic [DATA_W-1:0] lane_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            mask_q <= '0;
            reg_q  <= '0;
            rm_q   <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (latch_req) begin
                ctl_q.store   <= req_store;
                ctl_q.rm_mem  <= req_rm_mem;
                ctl_q.width   <= vwidth_e'(req_width);
                ctl_q.mask_en <= req_mask_en;
                ctl_q.zero    <= req_zero;
                mask_q        <= req_mask;
                reg_q         <= req_reg_idx;
                rm_q          <= req_rm_idx;
                addr_q        <= req_addr;
            end
            if (cap_rf)  data_q <= rf_rdata;
            if (cap_mem) data_q <= mem_rdata;
        end
    end

    vmov_align_chk u_align (
        .addr_lo    (addr_q[5:0]),
        .width      (ctl_q.width),
        .misaligned (misaligned)
    );

    vmov_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .store      (ctl_q.store),
        .rm_mem     (ctl_q.rm_mem),
        .misaligned (misaligned),
        .latch_req  (latch_req),
        .cap_rf     (cap_rf),
        .cap_mem    (cap_mem),
        .mem_rd_en  (mem_rd_en),
        .mem_wr_en  (mem_wr_en),
        .rf_wr_en   (rf_wr_en),
        .done       (done),
        .fault      (fault)
    );

    vmov_lane_ctl #(.LANES(LANES)) u_lanes (
        .width   (ctl_q.width),
        .mask_en (ctl_q.mask_en),
        .zero    (ctl_q.zero),
        .to_mem  (ctl_q.store & ctl_q.rm_mem),
        .mask    (mask_q),
        .src     (data_q),
        .lane_wr (rf_wr_lane_en),
        .byte_en (mem_be),
        .wdata   (lane_wdata)
    );

    assign mem_addr  = addr_q;
    assign mem_wdata = lane_wdata;
    assign rf_wdata  = lane_wdata;
    assign rf_rd_idx = ctl_q.store ? reg_q : rm_q;
    assign rf_wr_idx = ctl_q.store ? rm_q : reg_q;

endmodule

// File: rtl/vmov_unit_chk.sv
module vmov_unit_chk
    import vmov_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int ADDR_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               done,
    input logic               fault,
    input logic               mem_rd_en,
    input logic               mem_wr_en,
    input logic               rf_wr_en,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic [LANES*4-1:0] mem_be,
    input logic [LANES-1:0]   rf_wr_lane_en,
    input vwidth_e            lat_width,
    input logic               lat_mask_en,
    input logic               lat_zero,
    input logic [LANES-1:0]   lat_mask
);

    logic addr_ok;
    always_comb begin
        case (lat_width)
            VW_128:  addr_ok = (mem_addr[3:0] == 4'd0);
            VW_256:  addr_ok = (mem_addr[4:0] == 5'd0);
            default: addr_ok = (mem_addr[5:0] == 6'd0);
        endcase
    end

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_write_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr_en || mem_wr_en) |=> done);

    p_read_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> (!mem_rd_en && !fault));

    p_aligned_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || mem_wr_en) |-> addr_ok);

    p_narrow_reg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr_en && lat_width == VW_128) |-> (rf_wr_lane_en[LANES-1:4] == '0));

    p_narrow_mem_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && lat_width == VW_128) |-> (mem_be[LANES*4-1:16] == '0));

    p_unmasked_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr_en && !lat_mask_en && lat_width == VW_512) |-> (&rf_wr_lane_en));

    p_merge_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr_en && lat_mask_en && !lat_zero) |-> ((rf_wr_lane_en & ~lat_mask) == '0));

endmodule

bind vmov_unit vmov_unit_chk #(.LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .done          (done),
    .fault         (fault),
    .mem_rd_en     (mem_rd_en),
    .mem_wr_en     (mem_wr_en),
    .rf_wr_en      (rf_wr_en),
    .mem_addr      (mem_addr),
    .mem_be        (mem_be),
    .rf_wr_lane_en (rf_wr_lane_en),
    .lat_width     (ctl_q.width),
    .lat_mask_en   (ctl_q.mask_en),
    .lat_zero      (ctl_q.zero),
    .lat_mask      (mask_q)
);

// File: tb/tb_vmov_unit.sv
module tb_vmov_unit;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic         req_valid = 1'b0, req_store = 1'b0, req_rm_mem = 1'b0;
    logic [1:0]   req_width = 2'd0;
    logic         req_mask_en = 1'b0, req_zero = 1'b0;
    logic [15:0]  req_mask = '0;
    logic [4:0]   req_reg_idx = '0, req_rm_idx = '0;
    logic [31:0]  req_addr = '0;
    logic         mem_rd_en, mem_wr_en, rf_wr_en, done, fault;
    logic [31:0]  mem_addr;
    logic [63:0]  mem_be;
    logic [511:0] mem_wdata, mem_rdata, rf_rdata, rf_wdata;
    logic [4:0]   rf_rd_idx, rf_wr_idx;
    logic [15:0]  rf_wr_lane_en;

    vmov_unit dut (.*);

    logic [511:0] rf_m   [32];
    logic [511:0] exp_rf [32];
    logic [7:0]   mem_m   [1024];
    logic [7:0]   exp_mem [1024];

    int total = 0, bad = 0, done_cnt = 0, fault_cnt = 0;

    function automatic logic [31:0] rf_init(int r, int i);
        return 32'(r * 65536 + i * 256 + 17);
    endfunction

    assign rf_rdata = rf_m[rf_rd_idx];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < 32; r++)
                for (int i = 0; i < 16; i++) rf_m[r][32*i +: 32] <= rf_init(r, i);
            for (int a = 0; a < 1024; a++) mem_m[a] <= 8'((a * 7 + 3) & 255);
            mem_rdata <= '0;
        end else begin
            if (rf_wr_en)
                for (int i = 0; i < 16; i++)
                    if (rf_wr_lane_en[i]) rf_m[rf_wr_idx][32*i +: 32] <= rf_wdata[32*i +: 32];
            if (mem_wr_en)
                for (int b = 0; b < 64; b++)
                    if (mem_be[b]) mem_m[(int'(mem_addr) + b) % 1024] <= mem_wdata[8*b +: 8];
            if (mem_rd_en)
                for (int b = 0; b < 64; b++)
                    mem_rdata[8*b +: 8] <= mem_m[(int'(mem_addr) + b) % 1024];
            if (done)  done_cnt  <= done_cnt + 1;
            if (fault) fault_cnt <= fault_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        int er = -1, em = -1;
        for (int r = 0; r < 32; r++) if (er < 0 && rf_m[r] !== exp_rf[r]) er = r;
        for (int a = 0; a < 1024; a++) if (em < 0 && mem_m[a] !== exp_mem[a]) em = a;
        if (er < 0) chk(1, tag, "regfile", '0, '0);
        else chk(0, tag, $sformatf("reg %0d", er), rf_m[er], exp_rf[er]);
        if (em < 0) chk(1, tag, "memory", '0, '0);
        else chk(0, tag, $sformatf("mem byte %0d", em), 512'(mem_m[em]), 512'(exp_mem[em]));
    endtask

    task automatic run_op(input bit st, input bit rmm, input int w, input bit men,
                          input bit z, input logic [15:0] mk, input int rg, input int rm,
                          input int ad, input string tag, input bit intrude);
        int n, d0, f0, dst;
        bit expf, sel;
        logic [511:0] src;
        n = 4 << w;
        expf = rmm && ((ad % (16 << w)) != 0);
        if (!expf) begin
            if (!st) begin
                if (rmm) for (int b = 0; b < 64; b++) src[8*b +: 8] = exp_mem[(ad + b) % 1024];
                else src = exp_rf[rm];
            end else src = exp_rf[rg];
            if (st && rmm) begin
                for (int i = 0; i < n; i++) begin
                    sel = !men || mk[i];
                    if (sel) for (int k = 0; k < 4; k++)
                        exp_mem[(ad + 4*i + k) % 1024] = src[32*i + 8*k +: 8];
                end
            end else begin
                dst = st ? rm : rg;
                for (int i = 0; i < n; i++) begin
                    sel = !men || mk[i];
                    if (sel) exp_rf[dst][32*i +: 32] = src[32*i +: 32];
                    else if (z) exp_rf[dst][32*i +: 32] = '0;
                end
            end
        end
        d0 = done_cnt; f0 = fault_cnt;
        @(negedge clk);
        req_valid = 1; req_store = st; req_rm_mem = rmm; req_width = 2'(w);
        req_mask_en = men; req_zero = z; req_mask = mk;
        req_reg_idx = 5'(rg); req_rm_idx = 5'(rm); req_addr = 32'(ad);
        @(negedge clk);
        req_valid = 0;
        if (intrude) begin
            @(negedge clk);
            req_valid = 1; req_store = 0; req_rm_mem = 0; req_mask_en = 0;
            req_width = 2'd2; req_reg_idx = 5'((rg + 1) % 32); req_rm_idx = 5'((rm + 5) % 32);
            @(negedge clk);
            req_valid = 0;
        end
        for (int c = 0; c < 40 && done_cnt == d0 && fault_cnt == f0; c++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk((done_cnt - d0) == (expf ? 0 : 1) && (fault_cnt - f0) == (expf ? 1 : 0),
            tag, "done/fault pulses",
            512'((done_cnt - d0) * 16 + (fault_cnt - f0)), 512'(expf ? 1 : 16));
        compare_all(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] masks [3];
        string tag;
        masks[0] = 16'h0000; masks[1] = 16'h5A3C; masks[2] = 16'h8001;
        for (int r = 0; r < 32; r++)
            for (int i = 0; i < 16; i++) exp_rf[r][32*i +: 32] = rf_init(r, i);
        for (int a = 0; a < 1024; a++) exp_mem[a] = 8'((a * 7 + 3) & 255);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: idle outputs after reset
        chk(!done && !fault && !mem_rd_en && !mem_wr_en && !rf_wr_en, "R10", "reset outputs",
            512'({done, fault, mem_rd_en, mem_wr_en, rf_wr_en}), '0);

        // main sweep: R1 R4 R5 R6 R7 R8 R9
        for (int w = 0; w < 3; w++)
            for (int dm = 0; dm < 4; dm++)
                for (int mm = 0; mm < 3; mm++)
                    for (int mi = 0; mi < 3; mi++) begin
                        int k, ad;
                        k = w * 36 + dm * 9 + mm * 3 + mi;
                        ad = (k % 16) * 64 + ((k * 5) % (4 >> w)) * (16 << w);
                        if (mm == 0) tag = "R5";
                        else if (dm == 2) tag = "R8";
                        else if (mm == 1) tag = "R6";
                        else tag = "R7";
                        if (w == 0) tag = {tag, "/R9"};
                        tag = {tag, (dm[0] ? "/R4" : "/R1")};
                        run_op(dm >= 2, !dm[0], w, mm != 0, mm == 2, masks[mi],
                               k % 32, (k * 7 + 3) % 32, ad, tag, 1'b0);
                    end

        // misalignment sweep: R2
        for (int w = 0; w < 3; w++)
            for (int off = 1; off < 64; off++)
                if (off % (16 << w) != 0)
                    for (int st = 0; st < 2; st++)
                        run_op(st != 0, 1'b1, w, 1'b0, 1'b0, 16'hFFFF, (off + w) % 32,
                               (off * 3) % 32, 128 + off, "R2", 1'b0);

        // register-to-register with a misaligned address: R3
        for (int w = 0; w < 3; w++)
            for (int st = 0; st < 2; st++)
                run_op(st != 0, 1'b0, w, 1'b1, 1'b1, 16'h3C69, 4 + w, 20 + st, 7 + 9 * w,
                       "R3", 1'b0);

        // request during an operation is ignored: R10
        run_op(1'b0, 1'b1, 2, 1'b0, 1'b0, 16'h0, 9, 2, 256, "R10", 1'b1);
        run_op(1'b1, 1'b1, 1, 1'b1, 1'b0, 16'h00F3, 12, 3, 544, "R10", 1'b1);
        run_op(1'b0, 1'b0, 0, 1'b1, 1'b1, 16'h0005, 14, 30, 0, "R10", 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule